// File: doc/BRIEF.md
# PCI Bus Power-On Sequencer

This block brings an external PCI bus out of reset in a fixed order. One pulse on `start` begins the sequence. The block first turns on the output drivers for the bus reset and the bus clock. It then starts the bus clock while bus reset is still asserted. After a minimum reset hold it releases bus reset and hands bus arbitration to the on-chip arbiter. A short gap and then a long settle follow, and only after both does it raise `ready`.

All waits come from a single down-counter. They are given in microseconds and scaled by a parameter that sets how many system clock cycles make one microsecond. Every control output is driven straight from a flop, and each one changes exactly once in a sequence.

Top module: `pci_bus_bringup`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, all six outputs are 0. Bus reset is active-low on `bus_rst_n`, so 0 means bus reset is asserted.
- R2: While `start` is not pulsed after reset, all outputs stay 0.
- R3: One cycle after `start` is sampled high, `rst_drv_en` and `clk_drv_en` are 1, while `bus_clk_en` is 0 and `bus_rst_n` is 0.
- R4: One cycle after that, `bus_clk_en` is 1 and `bus_rst_n` is still 0.
- R5: `bus_rst_n` rises exactly CYC_PER_US*HOLD_US cycles after `bus_clk_en` rises. `arb_internal` rises in the same cycle as `bus_rst_n`.
- R6: `ready` rises exactly CYC_PER_US*(GAP_US+SETTLE_US) cycles after `bus_rst_n` rises.
- R7: Once an output has risen, it stays high until `rst_n` is asserted. In particular, `ready` stays high.
- R8: A `start` pulse given while a sequence is running, or after `ready`, has no effect on any output or on the timing.
- R9: Asserting `rst_n` in the middle of a sequence returns every output to 0. A later `start` then runs a full sequence with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start | input | 1 | Launches the sequence when the block is idle |
| rst_drv_en | output | 1 | Output enable for the bus reset driver |
| clk_drv_en | output | 1 | Output enable for the bus clock driver |
| bus_clk_en | output | 1 | Bus clock running |
| bus_rst_n | output | 1 | Bus reset, active low |
| arb_internal | output | 1 | Selects the on-chip bus arbiter |
| ready | output | 1 | Bus usable; stays high until block reset |

## Verification
The assertions assume that `rst_n` is the only way to abort a sequence. They also assume that every wait parameter is at least one cycle long, so each step takes at least one clock. `start` may be high at any time, even for several cycles.

The stimulus pulses `start` at random moments in every phase and holds it for random lengths. It also drops `rst_n` at a random point partway through a run. The wait parameters are scaled down so that several full sequences fit in one run.

// File: rtl/pci_bus_bringup.sv
module pci_bus_bringup #(
  parameter int CYC_PER_US = 100,
  parameter int HOLD_US    = 150,
  parameter int GAP_US     = 1,
  parameter int SETTLE_US  = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic rst_drv_en,
  output logic clk_drv_en,
  output logic bus_clk_en,
  output logic bus_rst_n,
  output logic arb_internal,
  output logic ready
);
  localparam int HOLD_CYC   = CYC_PER_US * HOLD_US;
  localparam int GAP_CYC    = CYC_PER_US * GAP_US;
  localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;
  localparam int MAX_A      = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
  localparam int MAX_CYC    = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int CW         = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_DRV, S_HOLD, S_GAP, S_SETTLE, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      rst_drv_en   <= 1'b0;
      clk_drv_en   <= 1'b0;
      bus_clk_en   <= 1'b0;
      bus_rst_n    <= 1'b0;
      arb_internal <= 1'b0;
      ready        <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st         <= S_DRV;
          rst_drv_en <= 1'b1;
          clk_drv_en <= 1'b1;
        end
        S_DRV: begin
          st         <= S_HOLD;
          bus_clk_en <= 1'b1;
          cnt        <= CW'(HOLD_CYC - 1);
        end
        S_HOLD: if (cnt_zero) begin
          st           <= S_GAP;
          bus_rst_n    <= 1'b1;
          arb_internal <= 1'b1;
          cnt          <= CW'(GAP_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_GAP: if (cnt_zero) begin
          st  <= S_SETTLE;
          cnt <= CW'(SETTLE_CYC - 1);
        end else cnt <= cnt - 1'b1;
        S_SETTLE: if (cnt_zero) begin
          st    <= S_DONE;
          ready <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  // Independent tally of cycles spent with clock on and bus reset still held
  logic [CW:0] held_cycles;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_cycles <= '0;
    else if (bus_clk_en && !bus_rst_n) held_cycles <= held_cycles + 1'b1;
  end

  p_drivers_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clk_en) |-> (rst_drv_en && clk_drv_en && !bus_rst_n));
  p_clk_before_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst_n) |-> bus_clk_en);
  p_hold_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rst_n) |-> (held_cycles == (CW+1)'(HOLD_CYC)));
  p_arb_with_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_internal) |-> $rose(bus_rst_n));
  p_ready_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (bus_rst_n && arb_internal && bus_clk_en));
  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_clk_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk_en |=> bus_clk_en);
  p_release_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_n |=> bus_rst_n);
endmodule

// File: tb/pci_bus_bringup_bench.sv
module pci_bus_bringup_bench;
  localparam int CPU = 3, HOLD = 150, GAP = 1, SETTLE = 40;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic rst_drv_en, clk_drv_en, bus_clk_en, bus_rst_n, arb_internal, ready;
  int errors = 0, checks = 0;
  bit wd_hit = 1'b0;

  always #2.5 clk = ~clk;

  pci_bus_bringup #(.CYC_PER_US(CPU), .HOLD_US(HOLD), .GAP_US(GAP), .SETTLE_US(SETTLE)) u_pci_bus_bringup (
    .clk(clk), .rst_n(rst_n), .start(start), .rst_drv_en(rst_drv_en), .clk_drv_en(clk_drv_en),
    .bus_clk_en(bus_clk_en), .bus_rst_n(bus_rst_n), .arb_internal(arb_internal), .ready(ready));

  function automatic int exp_hold();
    return CPU * HOLD;
  endfunction
  function automatic int exp_tail();
    return CPU * (GAP + SETTLE);
  endfunction

  function automatic logic [5:0] outs();
    return {rst_drv_en, clk_drv_en, bus_clk_en, bus_rst_n, arb_internal, ready};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One full sequence, with random stray start pulses during the waits (R8) and monotonic checks (R7)
  task automatic run_seq();
    int n, held, tail;
    logic [5:0] prev;
    n = $urandom_range(0, 12);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R2 idle outputs", outs(), 0);
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3 drivers on, clock off, reset held", outs(), 6'b110000);
    @(negedge clk);
    chk("R4 clock on, reset held", outs(), 6'b111000);
    held = 1;
    prev = outs();
    while (!bus_rst_n && held < 10000) begin
      start = ($urandom_range(0, 7) == 0);
      @(negedge clk);
      if ((outs() & prev) != prev) chk("R7 output fell in hold", outs(), prev);
      prev = outs();
      if (!bus_rst_n) held++;
    end
    start = 1'b0;
    chk("R5 hold cycles (R8 stray starts)", held, exp_hold());
    chk("R5 arbiter selected with release", outs(), 6'b111110);
    tail = 1;
    while (!ready && tail < 10000) begin
      start = ($urandom_range(0, 5) == 0);
      @(negedge clk);
      if ((outs() & prev) != prev) chk("R7 output fell in settle", outs(), prev);
      prev = outs();
      if (!ready) tail++;
    end
    start = 1'b0;
    chk("R6 release-to-ready cycles", tail, exp_tail());
    for (int i = 0; i < 20; i++) begin
      start = $urandom_range(0, 1);
      @(negedge clk);
    end
    start = 1'b0;
    chk("R7 R8 ready sticky after stray starts", outs(), 6'b111111);
  endtask

  initial begin
    #(200000 * 5);
    wd_hit = 1'b1;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", outs(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after reset", outs(), 0);
    run_seq();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R9 reset clears outputs", outs(), 0);
      rst_n = 1'b1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat ($urandom_range(1, exp_hold() + exp_tail())) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 mid-sequence reset clears outputs", outs(), 0);
      rst_n = 1'b1;
      run_seq();
    end
    if (!wd_hit) begin
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule